// File: doc/BRIEF.md
# AXI4-Lite Secure Window Access Filter

This block sits in front of a protected AXI4-Lite slave. It checks every read and write request against a fixed table of address windows. Each window names the protection-attribute pattern it requires and the set of master IDs it admits. The master ID travels beside the AXI4-Lite channels. A request that falls in no window, or that meets the rules of the window it hits, reaches the slave unchanged. A refused request never reaches the slave. The filter completes it locally with an error response.

The read and write channels are separate state machines and never wait on each other. Each channel keeps one request in flight. After the filter accepts a request it holds its ready signals low until the master has taken the response. Each channel also has a sticky violation flag and the address of its first refused request, so the outcome can be seen at the ports.

The protection field keeps its standard bit meanings. Bit 0 is privileged (1) or normal (0). Bit 1 is non-secure (1) or secure (0). Bit 2 is instruction (1) or data (0).

Top module: `axil_sec_filter`

## Requirements
- R1: A request outside every window, or one allowed by its window, is forwarded with the same address, protection, ID, data and strobes, and the slave's data and response come back unchanged.
- R2: The secure memory window (base 0x0E000000, 16 MiB) and the secure serial-port window (base 0x09040000, 4 KiB) refuse any request whose protection bit 1 is 1. The last word inside a window is refused. The first address past its end is not checked.
- R3: The crypto window (base 0x0A100000, 4 KiB) admits only protection value 3'b001. Any other value, such as normal (3'b000) or instruction (3'b101), is refused.
- R4: A request with secure protection is still refused when its ID is not on the window's allow list. The serial-port window allows IDs 0 to 3 and the crypto window allows IDs 0 and 1.
- R5: A refused read returns one response with read data all zero and response code 2'b10. No read address is issued to the slave.
- R6: A refused write accepts its address and its data beat, then returns response code 2'b10. No write address, write data or non-zero write strobe is issued to the slave.
- R7: After a channel accepts a request, its ready outputs stay low until the master has accepted that request's response.
- R8: Reads and writes are filtered independently. A refused read does not affect a write that overlaps it in time.
- R9: Each channel has a violation flag that sets on its first refused request and stays set until reset. It also captures that request's address and keeps it when later requests are refused.
- R10: The write address and write data may arrive in the same cycle or in either order.
- R11: After reset all valid outputs are low, the idle ready outputs are high and both violation flags are clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_awvalid | input | 1 | Master write address valid |
| s_awready | output | 1 | Write address ready to master |
| s_awaddr | input | 32 | Master write address |
| s_awprot | input | 3 | Master write protection |
| s_awid | input | 4 | Master write ID (sideband) |
| s_wvalid | input | 1 | Master write data valid |
| s_wready | output | 1 | Write data ready to master |
| s_wdata | input | 32 | Master write data |
| s_wstrb | input | 4 | Master write strobes |
| s_bvalid | output | 1 | Write response valid to master |
| s_bready | input | 1 | Master write response ready |
| s_bresp | output | 2 | Write response code to master |
| s_arvalid | input | 1 | Master read address valid |
| s_arready | output | 1 | Read address ready to master |
| s_araddr | input | 32 | Master read address |
| s_arprot | input | 3 | Master read protection |
| s_arid | input | 4 | Master read ID (sideband) |
| s_rvalid | output | 1 | Read data valid to master |
| s_rready | input | 1 | Master read data ready |
| s_rdata | output | 32 | Read data to master |
| s_rresp | output | 2 | Read response code to master |
| m_awvalid | output | 1 | Write address valid to slave |
| m_awready | input | 1 | Slave write address ready |
| m_awaddr | output | 32 | Write address to slave |
| m_awprot | output | 3 | Write protection to slave |
| m_awid | output | 4 | Write ID to slave |
| m_wvalid | output | 1 | Write data valid to slave |
| m_wready | input | 1 | Slave write data ready |
| m_wdata | output | 32 | Write data to slave |
| m_wstrb | output | 4 | Write strobes to slave |
| m_bvalid | input | 1 | Slave write response valid |
| m_bready | output | 1 | Write response ready to slave |
| m_bresp | input | 2 | Slave write response code |
| m_arvalid | output | 1 | Read address valid to slave |
| m_arready | input | 1 | Slave read address ready |
| m_araddr | output | 32 | Read address to slave |
| m_arprot | output | 3 | Read protection to slave |
| m_arid | output | 4 | Read ID to slave |
| m_rvalid | input | 1 | Slave read data valid |
| m_rready | output | 1 | Read data ready to slave |
| m_rdata | input | 32 | Slave read data |
| m_rresp | input | 2 | Slave read response code |
| wr_viol | output | 1 | Sticky flag: a write was refused |
| wr_viol_addr | output | 32 | Address of the first refused write |
| rd_viol | output | 1 | Sticky flag: a read was refused |
| rd_viol_addr | output | 32 | Address of the first refused read |

## Verification
The hardest case to reach is a write whose address and data beats arrive on different cycles while a refused read elsewhere is still holding its error response open. This case tests two things at once: the write path has to keep its decision across the gap between the beats, and the two channels have to stay independent. The bench drives this case in three ways. A write task can present the address first, the data first, or both together. The response-ready signal can be withheld for several cycles so that a response stays open. A read task and a write task can run side by side in a fork. A slave model counts every address, data beat and non-zero strobe that reaches it, which shows whether a refused request leaked through.

// File: rtl/secflt_pkg.sv
package secflt_pkg;

    localparam int ADDR_W  = 32;
    localparam int DATA_W  = 32;
    localparam int STRB_W  = DATA_W / 8;
    localparam int ID_W    = 4;
    localparam int ID_N    = 1 << ID_W;
    localparam int PROT_W  = 3;
    localparam int RESP_W  = 2;
    localparam int NUM_WIN = 3;

    typedef logic [RESP_W-1:0] resp_t;
    localparam resp_t RESP_OKAY   = 2'b00;
    localparam resp_t RESP_SLVERR = 2'b10;

    // One protected address window: a request hits it when
    // base <= addr < base + size; it passes when (prot & prot_mask) == prot_val
    // and the bit of id_allow selected by the request ID is set.
    typedef struct packed {
        logic [ADDR_W-1:0] base;
        logic [ADDR_W-1:0] size;
        logic [PROT_W-1:0] prot_mask;
        logic [PROT_W-1:0] prot_val;
        logic [ID_N-1:0]   id_allow;
    } win_t;

    localparam win_t WIN_TABLE [NUM_WIN] = '{
        // secure memory: any secure request, any ID
        '{base: 32'h0E00_0000, size: 32'h0100_0000,
          prot_mask: 3'b010, prot_val: 3'b000, id_allow: 16'hFFFF},
        // secure serial port: secure requests from IDs 0..3
        '{base: 32'h0904_0000, size: 32'h0000_1000,
          prot_mask: 3'b010, prot_val: 3'b000, id_allow: 16'h000F},
        // crypto engine: privileged, secure, data only, IDs 0..1
        '{base: 32'h0A10_0000, size: 32'h0000_1000,
          prot_mask: 3'b111, prot_val: 3'b001, id_allow: 16'h0003}
    };

    typedef enum logic [1:0] {RD_IDLE, RD_FWD, RD_RSP, RD_ERR} rd_state_e;
    typedef enum logic [1:0] {WR_IDLE, WR_FWD, WR_RSP, WR_ERR} wr_state_e;

    typedef struct packed {
        rd_state_e         state;
        logic [ADDR_W-1:0] addr;
        logic [PROT_W-1:0] prot;
        logic [ID_W-1:0]   id;
        logic              viol;
        logic [ADDR_W-1:0] viol_addr;
    } rd_st_t;

    typedef struct packed {
        wr_state_e         state;
        logic [ADDR_W-1:0] addr;
        logic [PROT_W-1:0] prot;
        logic [ID_W-1:0]   id;
        logic [DATA_W-1:0] data;
        logic [STRB_W-1:0] strb;
        logic              aw_have;
        logic              w_have;
        logic              ok;
        logic              aw_sent;
        logic              w_sent;
        logic              viol;
        logic [ADDR_W-1:0] viol_addr;
    } wr_st_t;

endpackage

// File: rtl/secflt_win_match.sv
module secflt_win_match
    import secflt_pkg::*;
#(
    parameter int   N = NUM_WIN,
    parameter win_t WINS [N] = WIN_TABLE
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [PROT_W-1:0] prot,
    input  logic [ID_W-1:0]   id,
    output logic              allow
);

    logic [N-1:0] hit_v;
    logic [N-1:0] ok_v;

    for (genvar i = 0; i < N; i++) begin : g_win
        assign hit_v[i] = (addr >= WINS[i].base) &&
                          ((addr - WINS[i].base) < WINS[i].size);
        assign ok_v[i]  = ((prot & WINS[i].prot_mask) == WINS[i].prot_val) &&
                          WINS[i].id_allow[id];
    end

    // Lowest-numbered matching window decides; no match means pass.
    always_comb begin
        allow = 1'b1;
        for (int i = N - 1; i >= 0; i--) begin
            if (hit_v[i]) allow = ok_v[i];
        end
    end

endmodule

// File: rtl/secflt_rd_path.sv
module secflt_rd_path
    import secflt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              allow,
    input  logic              s_arvalid,
    output logic              s_arready,
    input  logic [ADDR_W-1:0] s_araddr,
    input  logic [PROT_W-1:0] s_arprot,
    input  logic [ID_W-1:0]   s_arid,
    output logic              s_rvalid,
    input  logic              s_rready,
    output logic [DATA_W-1:0] s_rdata,
    output logic [RESP_W-1:0] s_rresp,
    output logic              m_arvalid,
    input  logic              m_arready,
    output logic [ADDR_W-1:0] m_araddr,
    output logic [PROT_W-1:0] m_arprot,
    output logic [ID_W-1:0]   m_arid,
    input  logic              m_rvalid,
    output logic              m_rready,
    input  logic [DATA_W-1:0] m_rdata,
    input  logic [RESP_W-1:0] m_rresp,
    output logic              viol,
    output logic [ADDR_W-1:0] viol_addr
);

    rd_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        s_arready = 1'b0;
        s_rvalid  = 1'b0;
        s_rdata   = '0;
        s_rresp   = RESP_OKAY;
        m_arvalid = 1'b0;
        m_rready  = 1'b0;
        case (st_q.state)
            RD_IDLE: begin
                s_arready = 1'b1;
                if (s_arvalid) begin
                    st_d.addr  = s_araddr;
                    st_d.prot  = s_arprot;
                    st_d.id    = s_arid;
                    st_d.state = allow ? RD_FWD : RD_ERR;
                    if (!allow) begin
                        if (!st_q.viol) st_d.viol_addr = s_araddr;
                        st_d.viol = 1'b1;
                    end
                end
            end
            RD_FWD: begin
                m_arvalid = 1'b1;
                if (m_arready) st_d.state = RD_RSP;
            end
            RD_RSP: begin
                s_rvalid = m_rvalid;
                s_rdata  = m_rdata;
                s_rresp  = m_rresp;
                m_rready = s_rready;
                if (m_rvalid && s_rready) st_d.state = RD_IDLE;
            end
            RD_ERR: begin
                s_rvalid = 1'b1;
                s_rresp  = RESP_SLVERR;
                if (s_rready) st_d.state = RD_IDLE;
            end
            default: st_d.state = RD_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign m_araddr  = st_q.addr;
    assign m_arprot  = st_q.prot;
    assign m_arid    = st_q.id;
    assign viol      = st_q.viol;
    assign viol_addr = st_q.viol_addr;

    p_rd_deny_r5: assert property (@(posedge clk) disable iff (!rst_n)
        s_arvalid && s_arready && !allow |=>
            s_rvalid && s_rresp == RESP_SLVERR && s_rdata == '0 && !m_arvalid);

    p_rd_fwd_r1: assert property (@(posedge clk) disable iff (!rst_n)
        s_arvalid && s_arready && allow |=>
            m_arvalid && m_araddr == $past(s_araddr));

    p_ar_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        m_arvalid && !m_arready |=> m_arvalid && $stable(m_araddr));

    p_rd_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        s_arvalid && s_arready |=> !s_arready);

    p_rd_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        viol |=> viol && $stable(viol_addr));

endmodule

// File: rtl/secflt_wr_path.sv
module secflt_wr_path
    import secflt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              allow,
    input  logic              s_awvalid,
    output logic              s_awready,
    input  logic [ADDR_W-1:0] s_awaddr,
    input  logic [PROT_W-1:0] s_awprot,
    input  logic [ID_W-1:0]   s_awid,
    input  logic              s_wvalid,
    output logic              s_wready,
    input  logic [DATA_W-1:0] s_wdata,
    input  logic [STRB_W-1:0] s_wstrb,
    output logic              s_bvalid,
    input  logic              s_bready,
    output logic [RESP_W-1:0] s_bresp,
    output logic              m_awvalid,
    input  logic              m_awready,
    output logic [ADDR_W-1:0] m_awaddr,
    output logic [PROT_W-1:0] m_awprot,
    output logic [ID_W-1:0]   m_awid,
    output logic              m_wvalid,
    input  logic              m_wready,
    output logic [DATA_W-1:0] m_wdata,
    output logic [STRB_W-1:0] m_wstrb,
    input  logic              m_bvalid,
    output logic              m_bready,
    input  logic [RESP_W-1:0] m_bresp,
    output logic              viol,
    output logic [ADDR_W-1:0] viol_addr
);

    wr_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        s_awready = 1'b0;
        s_wready  = 1'b0;
        s_bvalid  = 1'b0;
        s_bresp   = RESP_OKAY;
        m_awvalid = 1'b0;
        m_wvalid  = 1'b0;
        m_bready  = 1'b0;
        case (st_q.state)
            WR_IDLE: begin
                s_awready = !st_q.aw_have;
                s_wready  = !st_q.w_have;
                if (s_awvalid && s_awready) begin
                    st_d.aw_have = 1'b1;
                    st_d.addr    = s_awaddr;
                    st_d.prot    = s_awprot;
                    st_d.id      = s_awid;
                    st_d.ok      = allow;
                    if (!allow) begin
                        if (!st_q.viol) st_d.viol_addr = s_awaddr;
                        st_d.viol = 1'b1;
                    end
                end
                if (s_wvalid && s_wready) begin
                    st_d.w_have = 1'b1;
                    st_d.data   = s_wdata;
                    st_d.strb   = s_wstrb;
                end
                if (st_d.aw_have && st_d.w_have) begin
                    st_d.state   = st_d.ok ? WR_FWD : WR_ERR;
                    st_d.aw_have = 1'b0;
                    st_d.w_have  = 1'b0;
                    st_d.aw_sent = 1'b0;
                    st_d.w_sent  = 1'b0;
                end
            end
            WR_FWD: begin
                m_awvalid = !st_q.aw_sent;
                m_wvalid  = !st_q.w_sent;
                if (m_awvalid && m_awready) st_d.aw_sent = 1'b1;
                if (m_wvalid && m_wready)   st_d.w_sent  = 1'b1;
                if (st_d.aw_sent && st_d.w_sent) st_d.state = WR_RSP;
            end
            WR_RSP: begin
                s_bvalid = m_bvalid;
                s_bresp  = m_bresp;
                m_bready = s_bready;
                if (m_bvalid && s_bready) st_d.state = WR_IDLE;
            end
            WR_ERR: begin
                s_bvalid = 1'b1;
                s_bresp  = RESP_SLVERR;
                if (s_bready) st_d.state = WR_IDLE;
            end
            default: st_d.state = WR_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign m_awaddr  = st_q.addr;
    assign m_awprot  = st_q.prot;
    assign m_awid    = st_q.id;
    assign m_wdata   = st_q.data;
    assign m_wstrb   = m_wvalid ? st_q.strb : '0;
    assign viol      = st_q.viol;
    assign viol_addr = st_q.viol_addr;

    p_wr_deny_r6: assert property (@(posedge clk) disable iff (!rst_n)
        s_awvalid && s_awready && !allow |=> !m_awvalid && !m_wvalid);

    p_aw_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        m_awvalid && !m_awready |=> m_awvalid && $stable(m_awaddr));

    p_wr_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        s_bvalid |-> !s_awready && !s_wready);

    p_wr_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        viol |=> viol && $stable(viol_addr));

endmodule

// File: rtl/axil_sec_filter.sv
module axil_sec_filter
    import secflt_pkg::*;
#(
    parameter int   N_WIN = NUM_WIN,
    parameter win_t WINS [N_WIN] = WIN_TABLE
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              s_awvalid,
    output logic              s_awready,
    input  logic [ADDR_W-1:0] s_awaddr,
    input  logic [PROT_W-1:0] s_awprot,
    input  logic [ID_W-1:0]   s_awid,
    input  logic              s_wvalid,
    output logic              s_wready,
    input  logic [DATA_W-1:0] s_wdata,
    input  logic [STRB_W-1:0] s_wstrb,
    output logic              s_bvalid,
    input  logic              s_bready,
    output logic [RESP_W-1:0] s_bresp,
    input  logic              s_arvalid,
    output logic              s_arready,
    input  logic [ADDR_W-1:0] s_araddr,
    input  logic [PROT_W-1:0] s_arprot,
    input  logic [ID_W-1:0]   s_arid,
    output logic              s_rvalid,
    input  logic              s_rready,
    output logic [DATA_W-1:0] s_rdata,
    output logic [RESP_W-1:0] s_rresp,
    output logic              m_awvalid,
    input  logic              m_awready,
    output logic [ADDR_W-1:0] m_awaddr,
    output logic [PROT_W-1:0] m_awprot,
    output logic [ID_W-1:0]   m_awid,
    output logic              m_wvalid,
    input  logic              m_wready,
    output logic [DATA_W-1:0] m_wdata,
    output logic [STRB_W-1:0] m_wstrb,
    input  logic              m_bvalid,
    output logic              m_bready,
    input  logic [RESP_W-1:0] m_bresp,
    output logic              m_arvalid,
    input  logic              m_arready,
    output logic [ADDR_W-1:0] m_araddr,
    output logic [PROT_W-1:0] m_arprot,
    output logic [ID_W-1:0]   m_arid,
    input  logic              m_rvalid,
    output logic              m_rready,
    input  logic [DATA_W-1:0] m_rdata,
    input  logic [RESP_W-1:0] m_rresp,
    output logic              wr_viol,
    output logic [ADDR_W-1:0] wr_viol_addr,
    output logic              rd_viol,
    output logic [ADDR_W-1:0] rd_viol_addr
);

    logic ar_allow;
    logic aw_allow;

    secflt_win_match #(.N(N_WIN), .WINS(WINS)) u_ar_win (
        .addr  (s_araddr),
        .prot  (s_arprot),
        .id    (s_arid),
        .allow (ar_allow)
    );

    secflt_win_match #(.N(N_WIN), .WINS(WINS)) u_aw_win (
        .addr  (s_awaddr),
        .prot  (s_awprot),
        .id    (s_awid),
        .allow (aw_allow)
    );

    secflt_rd_path u_rd (
        .clk       (clk),
        .rst_n     (rst_n),
        .allow     (ar_allow),
        .s_arvalid (s_arvalid),
        .s_arready (s_arready),
        .s_araddr  (s_araddr),
        .s_arprot  (s_arprot),
        .s_arid    (s_arid),
        .s_rvalid  (s_rvalid),
        .s_rready  (s_rready),
        .s_rdata   (s_rdata),
        .s_rresp   (s_rresp),
        .m_arvalid (m_arvalid),
        .m_arready (m_arready),
        .m_araddr  (m_araddr),
        .m_arprot  (m_arprot),
        .m_arid    (m_arid),
        .m_rvalid  (m_rvalid),
        .m_rready  (m_rready),
        .m_rdata   (m_rdata),
        .m_rresp   (m_rresp),
        .viol      (rd_viol),
        .viol_addr (rd_viol_addr)
    );

    secflt_wr_path u_wr (
        .clk       (clk),
        .rst_n     (rst_n),
        .allow     (aw_allow),
        .s_awvalid (s_awvalid),
        .s_awready (s_awready),
        .s_awaddr  (s_awaddr),
        .s_awprot  (s_awprot),
        .s_awid    (s_awid),
        .s_wvalid  (s_wvalid),
        .s_wready  (s_wready),
        .s_wdata   (s_wdata),
        .s_wstrb   (s_wstrb),
        .s_bvalid  (s_bvalid),
        .s_bready  (s_bready),
        .s_bresp   (s_bresp),
        .m_awvalid (m_awvalid),
        .m_awready (m_awready),
        .m_awaddr  (m_awaddr),
        .m_awprot  (m_awprot),
        .m_awid    (m_awid),
        .m_wvalid  (m_wvalid),
        .m_wready  (m_wready),
        .m_wdata   (m_wdata),
        .m_wstrb   (m_wstrb),
        .m_bvalid  (m_bvalid),
        .m_bready  (m_bready),
        .m_bresp   (m_bresp),
        .viol      (wr_viol),
        .viol_addr (wr_viol_addr)
    );

endmodule

// File: tb/axil_sec_filter_tb.sv
module axil_sec_filter_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    always #10 clk = ~clk;   // 50 MHz

    logic        s_awvalid = 0, s_wvalid = 0, s_bready = 0, s_arvalid = 0, s_rready = 0;
    logic [31:0] s_awaddr = 0, s_wdata = 0, s_araddr = 0;
    logic [2:0]  s_awprot = 0, s_arprot = 0;
    logic [3:0]  s_awid = 0, s_arid = 0, s_wstrb = 0;
    logic        s_awready, s_wready, s_bvalid, s_arready, s_rvalid;
    logic [1:0]  s_bresp, s_rresp;
    logic [31:0] s_rdata;
    logic        m_awvalid, m_wvalid, m_bready, m_arvalid, m_rready;
    logic [31:0] m_awaddr, m_wdata, m_araddr;
    logic [2:0]  m_awprot, m_arprot;
    logic [3:0]  m_awid, m_arid, m_wstrb;
    logic        wr_viol, rd_viol;
    logic [31:0] wr_viol_addr, rd_viol_addr;

    // slave model
    logic        sl_rv, sl_bv, sl_awh, sl_wh;
    logic [31:0] sl_rdata, last_aw, last_w;
    logic [3:0]  last_strb, last_arid;
    int          ar_cnt, aw_cnt, w_cnt, strb_cnt;

    axil_sec_filter u_dut (
        .clk(clk), .rst_n(rst_n),
        .s_awvalid(s_awvalid), .s_awready(s_awready), .s_awaddr(s_awaddr),
        .s_awprot(s_awprot), .s_awid(s_awid),
        .s_wvalid(s_wvalid), .s_wready(s_wready), .s_wdata(s_wdata), .s_wstrb(s_wstrb),
        .s_bvalid(s_bvalid), .s_bready(s_bready), .s_bresp(s_bresp),
        .s_arvalid(s_arvalid), .s_arready(s_arready), .s_araddr(s_araddr),
        .s_arprot(s_arprot), .s_arid(s_arid),
        .s_rvalid(s_rvalid), .s_rready(s_rready), .s_rdata(s_rdata), .s_rresp(s_rresp),
        .m_awvalid(m_awvalid), .m_awready(1'b1), .m_awaddr(m_awaddr),
        .m_awprot(m_awprot), .m_awid(m_awid),
        .m_wvalid(m_wvalid), .m_wready(1'b1), .m_wdata(m_wdata), .m_wstrb(m_wstrb),
        .m_bvalid(sl_bv), .m_bready(m_bready), .m_bresp(2'b00),
        .m_arvalid(m_arvalid), .m_arready(1'b1), .m_araddr(m_araddr),
        .m_arprot(m_arprot), .m_arid(m_arid),
        .m_rvalid(sl_rv), .m_rready(m_rready), .m_rdata(sl_rdata), .m_rresp(2'b00),
        .wr_viol(wr_viol), .wr_viol_addr(wr_viol_addr),
        .rd_viol(rd_viol), .rd_viol_addr(rd_viol_addr)
    );

    always @(posedge clk) begin
        if (!rst_n) begin
            sl_rv <= 0; sl_bv <= 0; sl_awh <= 0; sl_wh <= 0;
            ar_cnt <= 0; aw_cnt <= 0; w_cnt <= 0; strb_cnt <= 0;
            sl_rdata <= 0; last_aw <= 0; last_w <= 0; last_strb <= 0; last_arid <= 0;
        end else begin
            if (m_wstrb != 0) strb_cnt <= strb_cnt + 1;
            if (m_arvalid) begin
                sl_rv <= 1; sl_rdata <= m_araddr ^ 32'h5A5A_5A5A;
                last_arid <= m_arid; ar_cnt <= ar_cnt + 1;
            end else if (sl_rv && m_rready) sl_rv <= 0;
            if (m_awvalid) begin sl_awh <= 1; last_aw <= m_awaddr; aw_cnt <= aw_cnt + 1; end
            if (m_wvalid) begin
                sl_wh <= 1; last_w <= m_wdata; last_strb <= m_wstrb; w_cnt <= w_cnt + 1;
            end
            if (sl_awh && sl_wh && !sl_bv) begin sl_bv <= 1; sl_awh <= 0; sl_wh <= 0; end
            if (sl_bv && m_bready) sl_bv <= 0;
        end
    end

    int n_tests = 0;
    int n_fail  = 0;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [31:0] a, input logic [2:0] p, input logic [3:0] id,
                      input int hold, output logic [31:0] d, output logic [1:0] r);
        s_araddr = a; s_arprot = p; s_arid = id; s_arvalid = 1;
        while (!s_arready) @(negedge clk);
        @(negedge clk);
        s_arvalid = 0;
        while (!s_rvalid) @(negedge clk);
        if (hold > 0) begin
            repeat (hold) @(negedge clk);
            check("R7 rd ready low while response open", {30'd0, s_arready, s_rvalid}, 32'd1);
        end
        d = s_rdata; r = s_rresp;
        s_rready = 1;
        @(negedge clk);
        s_rready = 0;
    endtask

    task automatic pump();
        while (s_awvalid || s_wvalid) begin
            logic aw_go, w_go;
            aw_go = s_awvalid && s_awready;
            w_go  = s_wvalid && s_wready;
            @(negedge clk);
            if (aw_go) s_awvalid = 0;
            if (w_go)  s_wvalid  = 0;
        end
    endtask

    // order: 0 together, 1 address first, 2 data first
    task automatic wr(input logic [31:0] a, input logic [2:0] p, input logic [3:0] id,
                      input logic [31:0] d, input logic [3:0] st, input int order,
                      input int hold, output logic [1:0] r);
        s_awaddr = a; s_awprot = p; s_awid = id; s_wdata = d; s_wstrb = st;
        s_awvalid = (order != 2);
        s_wvalid  = (order != 1);
        pump();
        if (order == 1) begin @(negedge clk); s_wvalid = 1; pump(); end
        if (order == 2) begin @(negedge clk); s_awvalid = 1; pump(); end
        while (!s_bvalid) @(negedge clk);
        if (hold > 0) begin
            repeat (hold) @(negedge clk);
            check("R7 wr ready low while response open",
                  {29'd0, s_awready, s_wready, s_bvalid}, 32'd1);
        end
        r = s_bresp;
        s_bready = 1;
        @(negedge clk);
        s_bready = 0;
    endtask

    task automatic t_reset();
        check("R11 s_arready", {31'd0, s_arready}, 1);
        check("R11 s_awready/s_wready", {30'd0, s_awready, s_wready}, 3);
        check("R11 valids low", {27'd0, s_rvalid, s_bvalid, m_arvalid, m_awvalid, m_wvalid}, 0);
        check("R11 flags clear", {30'd0, rd_viol, wr_viol}, 0);
    endtask

    task automatic t_outside();
        logic [31:0] d; logic [1:0] r;
        rd(32'h2000_0010, 3'b011, 4'd7, 0, d, r);
        check("R1 outside read data", d, 32'h2000_0010 ^ 32'h5A5A_5A5A);
        check("R1 outside read resp", {30'd0, r}, 0);
        check("R1 id forwarded", {28'd0, last_arid}, 7);
        wr(32'h2000_0020, 3'b010, 4'd9, 32'hCAFE_F00D, 4'hF, 0, 0, r);
        check("R1 outside write addr", last_aw, 32'h2000_0020);
        check("R1 outside write data", last_w, 32'hCAFE_F00D);
        check("R1 outside write strb", {28'd0, last_strb}, 32'hF);
        check("R1 outside write resp", {30'd0, r}, 0);
    endtask

    task automatic t_secmem();
        logic [31:0] d; logic [1:0] r; int c;
        rd(32'h0E00_0100, 3'b000, 4'd5, 0, d, r);
        check("R2 secure read ok", {30'd0, r}, 0);
        check("R2 secure read data", d, 32'h0E00_0100 ^ 32'h5A5A_5A5A);
        c = ar_cnt;
        rd(32'h0E00_0100, 3'b010, 4'd5, 0, d, r);
        check("R5 refused read resp", {30'd0, r}, 2);
        check("R5 refused read data", d, 0);
        check("R5 no slave read", ar_cnt, c);
        check("R9 rd flag", {31'd0, rd_viol}, 1);
        check("R9 rd first addr", rd_viol_addr, 32'h0E00_0100);
    endtask

    task automatic t_crypto();
        logic [31:0] d; logic [1:0] r;
        rd(32'h0A10_0000, 3'b001, 4'd1, 0, d, r);
        check("R3 crypto priv secure data ok", {30'd0, r}, 0);
        rd(32'h0A10_0004, 3'b000, 4'd1, 0, d, r);
        check("R3 crypto normal refused", {30'd0, r}, 2);
        rd(32'h0A10_0008, 3'b101, 4'd0, 0, d, r);
        check("R3 crypto instruction refused", {30'd0, r}, 2);
        check("R9 rd first addr kept", rd_viol_addr, 32'h0E00_0100);
    endtask

    task automatic t_idlist();
        logic [31:0] d; logic [1:0] r;
        rd(32'h0904_0004, 3'b000, 4'd2, 0, d, r);
        check("R4 uart allowed id", {30'd0, r}, 0);
        rd(32'h0904_0004, 3'b000, 4'd9, 0, d, r);
        check("R4 uart disallowed id", {30'd0, r}, 2);
        rd(32'h0A10_0010, 3'b001, 4'd2, 0, d, r);
        check("R4 crypto disallowed id", {30'd0, r}, 2);
        rd(32'h0904_0FFC, 3'b010, 4'd0, 0, d, r);
        check("R2 uart last word refused", {30'd0, r}, 2);
        rd(32'h0904_1000, 3'b010, 4'd0, 0, d, r);
        check("R2 past uart end passes", {30'd0, r}, 0);
        check("R2 past end data", d, 32'h0904_1000 ^ 32'h5A5A_5A5A);
    endtask

    task automatic t_wr_deny();
        logic [1:0] r; int a0, w0, s0;
        a0 = aw_cnt; w0 = w_cnt; s0 = strb_cnt;
        wr(32'h0E00_0040, 3'b010, 4'd0, 32'h1111_2222, 4'hF, 0, 0, r);
        check("R6 refused write resp", {30'd0, r}, 2);
        check("R6 no slave addr", aw_cnt, a0);
        check("R6 no slave data", w_cnt, w0);
        check("R6 no strobe", strb_cnt, s0);
        check("R9 wr flag", {31'd0, wr_viol}, 1);
        check("R9 wr first addr", wr_viol_addr, 32'h0E00_0040);
    endtask

    task automatic t_order();
        logic [1:0] r; int a0;
        wr(32'h0E00_0080, 3'b000, 4'd3, 32'hA5A5_0001, 4'h3, 2, 0, r);
        check("R10 data-first write resp", {30'd0, r}, 0);
        check("R10 data-first write data", last_w, 32'hA5A5_0001);
        check("R10 data-first write strb", {28'd0, last_strb}, 32'h3);
        wr(32'h0E00_00C0, 3'b000, 4'd3, 32'hA5A5_0002, 4'hC, 1, 0, r);
        check("R10 addr-first write addr", last_aw, 32'h0E00_00C0);
        check("R10 addr-first write data", last_w, 32'hA5A5_0002);
        a0 = aw_cnt;
        wr(32'h0A10_0000, 3'b011, 4'd0, 32'h0, 4'hF, 1, 0, r);
        check("R10 addr-first refused write", {30'd0, r}, 2);
        check("R6 addr-first refused no slave", aw_cnt, a0);
        check("R9 wr first addr kept", wr_viol_addr, 32'h0E00_0040);
    endtask

    task automatic t_hold();
        logic [31:0] d; logic [1:0] r;
        rd(32'h0E00_0000, 3'b110, 4'd0, 3, d, r);
        check("R7 held refused read resp", {30'd0, r}, 2);
        wr(32'h2000_0000, 3'b000, 4'd0, 32'h7, 4'h1, 0, 3, r);
        check("R7 held write resp", {30'd0, r}, 0);
    endtask

    task automatic t_parallel();
        logic [31:0] d; logic [1:0] rr, wrr;
        fork
            rd(32'h0904_0008, 3'b000, 4'd12, 2, d, rr);
            wr(32'h2000_0100, 3'b010, 4'd12, 32'hBEEF_0100, 4'hF, 1, 0, wrr);
        join
        check("R8 read refused alongside write", {30'd0, rr}, 2);
        check("R8 write unaffected resp", {30'd0, wrr}, 0);
        check("R8 write reached slave", last_w, 32'hBEEF_0100);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_outside();
        t_secmem();
        t_crypto();
        t_idlist();
        t_wr_deny();
        t_order();
        t_hold();
        t_parallel();
        repeat (3) @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule